// File: doc/BRIEF.md
# Configuration Request Address Generator

This block turns one configuration request (bus, device, function and register offset) into the register-space actions that a root complex controller must carry out to reach it. Each request takes one of three routes. A request for the root complex itself, on bus 0, becomes a single access whose address is the register offset. A request for any device further down the hierarchy first causes a write of an encoded routing word into an index register. After that write, the access itself is made through a fixed data window. A request that names a device that cannot exist is refused.

The rule for refusal is about the first two buses. Bus 0 holds only the root complex, and bus 1 holds only the device directly attached to it. On either of those buses, any device number other than 0 is refused with a one-cycle error pulse. A refused request produces no write strobe and no access, and it leaves the index register as it was.

The caller presents a request with a valid/ready handshake. A new request is taken only after the previous one has finished. Every address the block produces is an offset from the controller's register base. The bus transaction and the data path stay outside this block.

Top module: `cfg_addr_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `idx_wr`, `acc_valid` and `err` are 0, and `idx_data` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance through the last output cycle of that request. It is 1 again in the cycle that follows.
- R3: A request whose bus is 0 or 1 and whose device is not 0 raises `err` for exactly one cycle, the cycle after acceptance. That request raises neither `idx_wr` nor `acc_valid`.
- R4: Rejected requests and bus-0 requests leave `idx_data` unchanged.
- R5: A bus-0 request with device 0 raises `acc_valid` for one cycle, the cycle after acceptance, with `out_addr` equal to the zero-extended register offset. No `idx_wr` is raised for it.
- R6: The index word places the bus number at bits 27:20, the device number at bits 19:15 and the function number at bits 14:12. All other bits are 0.
- R7: A request on any bus other than 0 that is not rejected raises `idx_wr` for one cycle, the cycle after acceptance. In that cycle `out_addr` is 0x9000 and `idx_data` is the index word. In the next cycle `acc_valid` is 1 and `out_addr` is 0x8000 plus the register offset.
- R8: On bus 1, device 0 with any function number takes the indexed route of R7.
- R9: On bus 0, the function number has no effect on `out_addr`.
- R10: Request fields are captured at acceptance. Values on the request inputs while the block is busy do not affect its outputs, and no second request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_off | input | 12 | Configuration register offset |
| idx_wr | output | 1 | Strobe: write `idx_data` to the index register at `out_addr` |
| idx_data | output | 32 | Current index register contents |
| acc_valid | output | 1 | Configuration access at `out_addr` |
| out_addr | output | 16 | Address relative to controller base |
| err | output | 1 | Request rejected (one-cycle pulse) |

## Verification
The bench aims at the edges of the refusal rule. It sends bus 1 with device 0, which must be indexed, and bus 0 or 1 with a nonzero device, which must be refused. It also sends bus 2 with a nonzero device, which must be allowed. A classifier that tested only bus 0 would index a bus-1 non-zero device instead of refusing it. A classifier whose comparison was off by one would refuse bus 2. The bench checks that the index register holds its contents across refused and direct requests. A design that loaded it on every acceptance would show the stale request's index word. It also scrambles the request inputs while the block is busy, so a design that read live inputs instead of captured ones would present wrong addresses. Finally it sends offsets at both ends of the range and fields at their maximum values, which expose shift or window-base mistakes in the index word and the window address.

// File: rtl/cfg_addr_pkg.sv
package cfg_addr_pkg;

   typedef enum logic [1:0] {
      RT_REJECT  = 2'd0,
      RT_DIRECT  = 2'd1,
      RT_INDEXED = 2'd2
   } route_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_REJ  = 3'd1,
      ST_DIR  = 3'd2,
      ST_IDX  = 3'd3,
      ST_WIN  = 3'd4
   } state_e;

endpackage

// File: rtl/cfg_req_classify.sv
module cfg_req_classify
   import cfg_addr_pkg::*;
#(
   parameter int BUS_W          = 8,
   parameter int DEV_W          = 5,
   parameter int NUM_SINGLE_BUS = 2
) (
   input  logic [BUS_W-1:0] bus,
   input  logic [DEV_W-1:0] dev,
   output route_e           route
);

   localparam int NSB = NUM_SINGLE_BUS;

   generate
      if (NSB < 1 || NSB > (1 << BUS_W)) begin : g_bad_nsb
         $error("NUM_SINGLE_BUS out of range");
      end
   endgenerate

   logic [NSB-1:0] single_hit;

   // one comparator per bus that holds only device 0
   generate
      for (genvar i = 0; i < NSB; i++) begin : g_single
         assign single_hit[i] = (bus == BUS_W'(i));
      end
   endgenerate

   logic on_root_bus;
   logic dev_zero;

   assign on_root_bus = single_hit[0];
   assign dev_zero    = (dev == '0);

   always_comb begin
      if ((|single_hit) && !dev_zero) begin
         route = RT_REJECT;
      end else if (on_root_bus) begin
         route = RT_DIRECT;
      end else begin
         route = RT_INDEXED;
      end
   end

endmodule

// File: rtl/cfg_index_enc.sv
module cfg_index_enc #(
   parameter int BUS_W      = 8,
   parameter int DEV_W      = 5,
   parameter int FUNC_W     = 3,
   parameter int IDX_W      = 32,
   parameter int BUS_SHIFT  = 20,
   parameter int DEV_SHIFT  = 15,
   parameter int FUNC_SHIFT = 12
) (
   input  logic [BUS_W-1:0]  bus,
   input  logic [DEV_W-1:0]  dev,
   input  logic [FUNC_W-1:0] func,
   output logic [IDX_W-1:0]  idx
);

   localparam int FUNC_TOP = FUNC_SHIFT + FUNC_W;
   localparam int DEV_TOP  = DEV_SHIFT + DEV_W;
   localparam int BUS_TOP  = BUS_SHIFT + BUS_W;

   generate
      if (FUNC_TOP > DEV_SHIFT) begin : g_ovl_fd
         $error("function field overlaps device field");
      end
      if (DEV_TOP > BUS_SHIFT) begin : g_ovl_db
         $error("device field overlaps bus field");
      end
      if (BUS_TOP > IDX_W) begin : g_ovf_bus
         $error("bus field does not fit index word");
      end
   endgenerate

   logic [IDX_W-1:0] bus_part;
   logic [IDX_W-1:0] dev_part;
   logic [IDX_W-1:0] func_part;

   assign bus_part  = IDX_W'(bus)  << BUS_SHIFT;
   assign dev_part  = IDX_W'(dev)  << DEV_SHIFT;
   assign func_part = IDX_W'(func) << FUNC_SHIFT;
   assign idx       = bus_part | dev_part | func_part;

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
   import cfg_addr_pkg::*;
#(
   parameter int              OFF_W       = 12,
   parameter int              ADDR_W      = 16,
   parameter int              IDX_W       = 32,
   parameter logic [ADDR_W-1:0] WIN_BASE    = 16'h8000,
   parameter logic [ADDR_W-1:0] IDX_REG_OFF = 16'h9000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  route_e            route,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [IDX_W-1:0]  idx_next,
   output logic              idx_wr,
   output logic [IDX_W-1:0]  idx_data,
   output logic              acc_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic              err
);

   localparam int OFF_SPAN = 1 << OFF_W;

   generate
      if (ADDR_W <= OFF_W) begin : g_bad_aw
         $error("address width must exceed offset width");
      end
      if ((int'(WIN_BASE) + OFF_SPAN) > (1 << ADDR_W)) begin : g_bad_win
         $error("data window does not fit address space");
      end
   endgenerate

   state_e           state_q;
   logic [OFF_W-1:0] off_q;
   logic [IDX_W-1:0] idx_q;
   logic             take;

   assign take = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         off_q   <= '0;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (take) begin
                  off_q <= req_off;
                  case (route)
                     RT_DIRECT:  state_q <= ST_DIR;
                     RT_INDEXED: begin
                        state_q <= ST_IDX;
                        idx_q   <= idx_next;
                     end
                     default:    state_q <= ST_REJ;
                  endcase
               end
            end
            ST_IDX:  state_q <= ST_WIN;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign err       = (state_q == ST_REJ);
   assign idx_wr    = (state_q == ST_IDX);
   assign acc_valid = (state_q == ST_DIR) || (state_q == ST_WIN);
   assign idx_data  = idx_q;

   always_comb begin
      case (state_q)
         ST_DIR:  out_addr = ADDR_W'(off_q);
         ST_IDX:  out_addr = IDX_REG_OFF;
         ST_WIN:  out_addr = WIN_BASE + ADDR_W'(off_q);
         default: out_addr = '0;
      endcase
   end

   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r3_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);

   a_r3_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err, idx_wr, acc_valid}));

   a_r7_strobe_then_window: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> (acc_valid && !idx_wr && !req_ready));

   a_r4_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_wr |-> $stable(idx_data));

   a_r5_direct_below_window: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !$past(idx_wr)) |-> (out_addr < WIN_BASE));

endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
   import cfg_addr_pkg::*;
#(
   parameter int                BUS_W          = 8,
   parameter int                DEV_W          = 5,
   parameter int                FUNC_W         = 3,
   parameter int                OFF_W          = 12,
   parameter int                ADDR_W         = 16,
   parameter int                IDX_W          = 32,
   parameter int                BUS_SHIFT      = 20,
   parameter int                DEV_SHIFT      = 15,
   parameter int                FUNC_SHIFT     = 12,
   parameter int                NUM_SINGLE_BUS = 2,
   parameter logic [ADDR_W-1:0] WIN_BASE       = 16'h8000,
   parameter logic [ADDR_W-1:0] IDX_REG_OFF    = 16'h9000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FUNC_W-1:0] req_func,
   input  logic [OFF_W-1:0]  req_off,
   output logic              idx_wr,
   output logic [IDX_W-1:0]  idx_data,
   output logic              acc_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic              err
);

   route_e           route;
   logic [IDX_W-1:0] idx_next;

   cfg_req_classify #(
      .BUS_W          (BUS_W),
      .DEV_W          (DEV_W),
      .NUM_SINGLE_BUS (NUM_SINGLE_BUS)
   ) i_classify (
      .bus   (req_bus),
      .dev   (req_dev),
      .route (route)
   );

   cfg_index_enc #(
      .BUS_W      (BUS_W),
      .DEV_W      (DEV_W),
      .FUNC_W     (FUNC_W),
      .IDX_W      (IDX_W),
      .BUS_SHIFT  (BUS_SHIFT),
      .DEV_SHIFT  (DEV_SHIFT),
      .FUNC_SHIFT (FUNC_SHIFT)
   ) i_index_enc (
      .bus  (req_bus),
      .dev  (req_dev),
      .func (req_func),
      .idx  (idx_next)
   );

   cfg_seq #(
      .OFF_W       (OFF_W),
      .ADDR_W      (ADDR_W),
      .IDX_W       (IDX_W),
      .WIN_BASE    (WIN_BASE),
      .IDX_REG_OFF (IDX_REG_OFF)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .route     (route),
      .req_off   (req_off),
      .idx_next  (idx_next),
      .idx_wr    (idx_wr),
      .idx_data  (idx_data),
      .acc_valid (acc_valid),
      .out_addr  (out_addr),
      .err       (err)
   );

endmodule

// File: tb/test_cfg_addr_gen.sv
`timescale 1ns/1ps
module test_cfg_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_bus = '0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [11:0] req_off = '0;
   logic        idx_wr;
   logic [31:0] idx_data;
   logic        acc_valid;
   logic [15:0] out_addr;
   logic        err;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   logic [31:0] idx_model = '0;

   always #4 clk = ~clk;

   cfg_addr_gen i_cfg_addr_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_bus   (req_bus),
      .req_dev   (req_dev),
      .req_func  (req_func),
      .req_off   (req_off),
      .idx_wr    (idx_wr),
      .idx_data  (idx_data),
      .acc_valid (acc_valid),
      .out_addr  (out_addr),
      .err       (err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // 0 reject, 1 direct, 2 indexed
   function automatic int exp_route(input logic [7:0] b, input logic [4:0] d);
      if (b < 8'd2 && d != 5'd0) return 0;
      if (b == 8'd0) return 1;
      return 2;
   endfunction

   function automatic logic [31:0] exp_idx(input logic [7:0] b, input logic [4:0] d,
                                           input logic [2:0] f);
      return {4'b0, b, d, f, 12'b0};
   endfunction

   task automatic run_req(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                          input logic [11:0] o, input bit scramble);
      int    rt;
      string atag;
      rt = exp_route(b, d);
      @(negedge clk);
      check("R2 ready before request", 32'(req_ready), 32'd1);
      req_bus = b; req_dev = d; req_func = f; req_off = o; req_valid = 1'b1;
      @(negedge clk);
      if (scramble) begin
         req_bus = 8'($urandom); req_dev = 5'($urandom);
         req_func = 3'($urandom); req_off = 12'($urandom); req_valid = 1'b1;
      end else begin
         req_valid = 1'b0;
      end
      check("R2 ready low while busy", 32'(req_ready), 32'd0);
      case (rt)
         0: begin
            check("R3 err raised", 32'(err), 32'd1);
            check("R3 no idx_wr on reject", 32'(idx_wr), 32'd0);
            check("R3 no acc_valid on reject", 32'(acc_valid), 32'd0);
            check("R4 index kept on reject", idx_data, idx_model);
         end
         1: begin
            atag = scramble ? "R10 direct address" : (f != 3'd0 ? "R9 direct address" : "R5 direct address");
            check("R5 acc_valid", 32'(acc_valid), 32'd1);
            check(atag, 32'(out_addr), 32'(o));
            check("R5 no idx_wr", 32'(idx_wr), 32'd0);
            check("R4 index kept on bus 0", idx_data, idx_model);
         end
         default: begin
            check(b == 8'd1 ? "R8 bus1 indexed strobe" : "R7 index strobe", 32'(idx_wr), 32'd1);
            check("R7 index register address", 32'(out_addr), 32'h9000);
            check("R6 index word", idx_data, exp_idx(b, d, f));
            check("R7 no access with strobe", 32'(acc_valid), 32'd0);
            idx_model = exp_idx(b, d, f);
         end
      endcase
      @(negedge clk);
      req_valid = 1'b0;
      if (rt == 2) begin
         atag = scramble ? "R10 window address" : "R7 window address";
         check("R7 window access", 32'(acc_valid), 32'd1);
         check(atag, 32'(out_addr), 32'h8000 + 32'(o));
         check("R7 strobe single cycle", 32'(idx_wr), 32'd0);
         check("R2 ready low in window", 32'(req_ready), 32'd0);
         @(negedge clk);
      end
      check("R2 ready after completion", 32'(req_ready), 32'd1);
      check("R3 err single cycle", 32'(err), 32'd0);
      check("R10 no extra access", 32'(acc_valid), 32'd0);
      check("R10 no extra strobe", 32'(idx_wr), 32'd0);
      check("R4 index word after request", idx_data, idx_model);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R2 actual=%0d expected<=100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", 32'(req_ready), 32'd1);
      check("R1 idx_wr after reset", 32'(idx_wr), 32'd0);
      check("R1 acc_valid after reset", 32'(acc_valid), 32'd0);
      check("R1 err after reset", 32'(err), 32'd0);
      check("R1 idx_data after reset", idx_data, 32'd0);

      // directed corners
      run_req(8'd0, 5'd0, 3'd0, 12'h000, 1'b0);
      run_req(8'd0, 5'd0, 3'd5, 12'hFFF, 1'b0);
      run_req(8'd5, 5'd3, 3'd2, 12'h040, 1'b0);
      run_req(8'd0, 5'd1, 3'd0, 12'h010, 1'b0);
      run_req(8'd1, 5'd31, 3'd7, 12'h100, 1'b0);
      run_req(8'd1, 5'd0, 3'd7, 12'hFFC, 1'b0);
      run_req(8'd2, 5'd31, 3'd7, 12'h000, 1'b0);
      run_req(8'd255, 5'd31, 3'd7, 12'hFFF, 1'b1);
      run_req(8'd0, 5'd0, 3'd1, 12'h3A8, 1'b1);
      run_req(8'd1, 5'd2, 3'd0, 12'h004, 1'b1);

      // constrained random
      for (int i = 0; i < 400; i++) begin
         logic [7:0] b;
         logic [4:0] d;
         case ($urandom % 4)
            0:       b = 8'd0;
            1:       b = 8'd1;
            default: b = 8'($urandom);
         endcase
         d = ($urandom % 2 == 0) ? 5'd0 : 5'($urandom);
         run_req(b, d, 3'($urandom), 12'($urandom), 1'($urandom));
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule